// File: doc/BRIEF.md
# Low-Power Real-Time Clock Counter with Seconds Alarm

This peripheral keeps time with a 47-bit counter that advances on each pulse of a slow tick enable, nominally 32.768 kHz. The lowest 15 bits count sub-second ticks, so the whole-seconds value is the counter shifted right by 15. Software reads and writes the block through a simple 32-bit word port. Reads are combinational on the current address. A write is a single-cycle strobe.

Setting or clearing the run bit does not reach the counter at once. The request must first cross a chain of slow-tick stages, and the run bit read back from the control word shows the synchronised value. Software therefore polls it. The counter can be loaded only while that synchronised run bit is low. A 32-bit alarm value is compared with the seconds field. When they match and the alarm is armed, a sticky flag is raised. That flag drives an interrupt and, when wakeup is enabled, a wakeup line. A plain 32-bit glitch-detector word completes the register set.

Top module: `rtc_lp_top`

## Requirements
- R1: After reset, every register reads zero, and `irq` and `wake` are low.
- R2: Control word at 0x04 has run at bit 0, alarm arm at bit 1 and wakeup enable at bit 3. Bits 1 and 3 read back as soon as they are written. Bit 0 reads the synchronised run value, which follows a written request only on the third `slow_tick` pulse after the write. It does not change without a pulse.
- R3: While the synchronised run bit is 1, each `slow_tick` pulse adds one to the counter, and all ones wraps to zero. The counter holds when there is no pulse, and it holds while the synchronised run bit is 0.
- R4: Offset 0x1C reads counter bits 46:32 in bits 14:0, with the upper bits zero. Offset 0x20 reads counter bits 31:0.
- R5: While the synchronised run bit is 0, a write to 0x1C loads counter bits 46:32 from wdata[14:0], and a write to 0x20 loads bits 31:0. While it is 1, both writes are ignored.
- R6: The alarm word at 0x24 is read/write. The flag in bit 0 of status at 0x18 sets in the cycle after the alarm is armed and counter bits 46:15 equal the alarm word. Once set, it stays set until cleared.
- R7: Writing a 1 to status bit 0 clears the flag, and so does writing all ones. Writing a 0 to that bit leaves the flag unchanged.
- R8: `irq` is the flag AND alarm arm. `wake` is `irq` AND wakeup enable.
- R9: Offset 0x30 is a 32-bit word that reads back what was written to it, for example 0x41736166.
- R10: Any other offset, including a misaligned one, reads zero, and writes to it change nothing.
- R11: If a match and a clearing write happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Alarm wakeup request |

## Verification
The counter is tried with four kinds of stimulus:
- Pulses arriving while the run request is still crossing the stages. This separates the synchronised enable from the written one.
- Pulses after the counter was preloaded to all ones. This exposes the wrap.
- Load writes made while running and while stopped. These show whether the load gating works.
- A preload just below an alarm second. This shows whether the match is taken on bits 46:15, and not on the raw count.

Alarm stimulus then checks three things: that the flag stays set when the match goes away, that a write of zero and a clear that coincides with a live match both leave the flag set, and that the interrupt and wakeup lines follow the arm and wakeup bits. A behavioural model in the bench predicts every register and output on every clock.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CNTH = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_CNTL = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_ALRM = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_GLCH = 8'h30;

    localparam int BIT_RUN  = 0;
    localparam int BIT_ARM  = 1;
    localparam int BIT_WAKE = 3;
    localparam int BIT_FLAG = 0;

    typedef struct packed {
        logic              run_req;
        logic              arm;
        logic              wake_en;
        logic              flag;
        logic [DATA_W-1:0] alarm;
        logic [DATA_W-1:0] glitch;
    } rtc_regs_t;
endpackage

// File: rtl/rtc_lp_sync.sv
module rtc_lp_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    output logic synced
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = tick ? req : chain_q;
        end else begin : g_multi
            always_comb chain_d = tick ? {chain_q[STAGES-2:0], req} : chain_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign synced = chain_q[STAGES-1];

    AST_SYNC_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(synced)); // R2
endmodule

// File: rtl/rtc_lp_counter.sv
module rtc_lp_counter #(
    parameter int CNT_W  = 47,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [DATA_W-1:0] ld_data,
    output logic [CNT_W-1:0]  count
);
    localparam int HI_W = CNT_W - DATA_W;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run) begin
            if (tick) cnt_d = cnt_q + CNT_W'(1);
        end else begin
            if (ld_hi) cnt_d[CNT_W-1:DATA_W] = ld_data[HI_W-1:0];
            if (ld_lo) cnt_d[DATA_W-1:0]     = ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && tick |=> count == $past(count) + CNT_W'(1)); // R3
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !ld_hi && !ld_lo |=> $stable(count)); // R3
    AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick |=> $stable(count)); // R5
endmodule

// File: rtl/rtc_lp_top.sv
module rtc_lp_top
    import rtc_lp_pkg::*;
#(
    parameter int CNT_W      = 47,
    parameter int FRAC_W     = 15,
    parameter int SYNC_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              wake
);
    localparam int SEC_W = CNT_W - FRAC_W;
    localparam int HI_W  = CNT_W - DATA_W;

    rtc_regs_t        regs_d, regs_q;
    logic [CNT_W-1:0] count;
    logic             run_sync;
    logic             wr_ctrl, wr_stat, wr_cnth, wr_cntl, wr_alrm, wr_glch;
    logic             match, clr;
    logic [SEC_W-1:0] secs;

    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
    assign wr_cnth = bus_wr && (bus_addr == OFS_CNTH);
    assign wr_cntl = bus_wr && (bus_addr == OFS_CNTL);
    assign wr_alrm = bus_wr && (bus_addr == OFS_ALRM);
    assign wr_glch = bus_wr && (bus_addr == OFS_GLCH);

    rtc_lp_sync #(.STAGES(SYNC_TICKS)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (slow_tick),
        .req    (regs_q.run_req),
        .synced (run_sync)
    );

    rtc_lp_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (slow_tick),
        .run     (run_sync),
        .ld_hi   (wr_cnth),
        .ld_lo   (wr_cntl),
        .ld_data (bus_wdata),
        .count   (count)
    );

    assign secs  = count[CNT_W-1:FRAC_W];
    assign match = regs_q.arm && (secs == regs_q.alarm);
    assign clr   = wr_stat && bus_wdata[BIT_FLAG];

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) begin
            regs_d.run_req = bus_wdata[BIT_RUN];
            regs_d.arm     = bus_wdata[BIT_ARM];
            regs_d.wake_en = bus_wdata[BIT_WAKE];
        end
        if (wr_alrm) regs_d.alarm  = bus_wdata;
        if (wr_glch) regs_d.glitch = bus_wdata;
        regs_d.flag = (regs_q.flag && !clr) || match;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[BIT_RUN]  = run_sync;
                bus_rdata[BIT_ARM]  = regs_q.arm;
                bus_rdata[BIT_WAKE] = regs_q.wake_en;
            end
            OFS_STAT: bus_rdata[BIT_FLAG] = regs_q.flag;
            OFS_CNTH: bus_rdata[HI_W-1:0] = count[CNT_W-1:DATA_W];
            OFS_CNTL: bus_rdata = count[DATA_W-1:0];
            OFS_ALRM: bus_rdata = regs_q.alarm;
            OFS_GLCH: bus_rdata = regs_q.glitch;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq  = regs_q.flag && regs_q.arm;
    assign wake = irq && regs_q.wake_en;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.flag && !clr |=> regs_q.flag); // R6
    AST_MATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> regs_q.flag); // R11
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !match |=> !regs_q.flag); // R7
endmodule

// File: tb/test_rtc_lp_top.sv
`timescale 1ns/1ps
module test_rtc_lp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq, wake;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    rtc_lp_top i_rtc_lp_top (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wake(wake)
    );

    // behavioural reference model
    bit        m_sync[$] = '{1'b0, 1'b0, 1'b0};
    bit        m_req, m_arm, m_wen, m_flag;
    bit [46:0] m_cnt;
    bit [31:0] m_alarm, m_glitch;
    bit        t_en, t_req, t_match;

    function automatic bit [31:0] exp_rd(bit [7:0] a);
        case (a)
            8'h04: return {28'h0, m_wen, 1'b0, m_arm, m_sync[2]};
            8'h18: return {31'h0, m_flag};
            8'h1C: return {17'h0, m_cnt[46:32]};
            8'h20: return m_cnt[31:0];
            8'h24: return m_alarm;
            8'h30: return m_glitch;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(bit [7:0] a);
        case (a)
            8'h04: return "R2";
            8'h18: return "R6";
            8'h1C: return "R4";
            8'h20: return "R3";
            8'h24: return "R6";
            8'h30: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sync = '{1'b0, 1'b0, 1'b0};
            m_req = 0; m_arm = 0; m_wen = 0; m_flag = 0;
            m_cnt = '0; m_alarm = '0; m_glitch = '0;
        end else begin
            t_en    = m_sync[2];
            t_req   = m_req;
            t_match = m_arm && (m_cnt[46:15] == m_alarm);
            if (slow_tick) begin
                m_sync.push_front(t_req);
                void'(m_sync.pop_back());
            end
            if (t_en) begin
                if (slow_tick) m_cnt = m_cnt + 1;
            end else if (bus_wr) begin
                if (bus_addr == 8'h1C) m_cnt[46:32] = bus_wdata[14:0];
                if (bus_addr == 8'h20) m_cnt[31:0]  = bus_wdata;
            end
            m_flag = (m_flag && !(bus_wr && bus_addr == 8'h18 && bus_wdata[0])) || t_match;
            if (bus_wr && bus_addr == 8'h04) begin
                m_req = bus_wdata[0]; m_arm = bus_wdata[1]; m_wen = bus_wdata[3];
            end
            if (bus_wr && bus_addr == 8'h24) m_alarm  = bus_wdata;
            if (bus_wr && bus_addr == 8'h30) m_glitch = bus_wdata;
            #5;
            chk(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
            chk("R8 irq", {31'h0, irq}, {31'h0, m_flag && m_arm});
            chk("R8 wake", {31'h0, wake}, {31'h0, m_flag && m_arm && m_wen});
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk); bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pins(logic ei, logic ew, string tag);
        @(negedge clk); #1;
        chk(tag, {30'h0, irq, wake}, {30'h0, ei, ew});
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h04, 32'h0, "R1 ctrl");
        rd(8'h18, 32'h0, "R1 stat");
        rd(8'h20, 32'h0, "R1 cntl");
        rd(8'h24, 32'h0, "R1 alarm");
        pins(1'b0, 1'b0, "R1 pins");
        // R9 glitch word
        wr(8'h30, 32'h41736166);
        rd(8'h30, 32'h41736166, "R9 glitch");
        // R10 unmapped / misaligned
        wr(8'h08, 32'hFFFFFFFF);
        wr(8'h1A, 32'hFFFFFFFF);
        rd(8'h08, 32'h0, "R10 unmapped read");
        rd(8'h1A, 32'h0, "R10 misaligned read");
        rd(8'h04, 32'h0, "R10 ctrl untouched");
        rd(8'h20, 32'h0, "R10 counter untouched");
        // R5 load while stopped, R4 high field width
        wr(8'h1C, 32'hFFFFFFFF);
        wr(8'h20, 32'hFFFFFFFF);
        rd(8'h1C, 32'h00007FFF, "R4 high field");
        rd(8'h20, 32'hFFFFFFFF, "R5 low load");
        // R2 run request crosses three ticks
        wr(8'h04, 32'h1);
        ticks(2);
        rd(8'h04, 32'h0, "R2 run not yet visible");
        ticks(1);
        rd(8'h04, 32'h1, "R2 run visible");
        rd(8'h20, 32'hFFFFFFFF, "R3 no step before sync");
        // R3 wrap
        ticks(1);
        rd(8'h20, 32'h0, "R3 wrap low");
        rd(8'h1C, 32'h0, "R3 wrap high");
        ticks(3);
        rd(8'h20, 32'h3, "R3 step");
        // R5 ignored while running
        wr(8'h20, 32'h100);
        wr(8'h1C, 32'h5);
        rd(8'h20, 32'h3, "R5 ignored low");
        rd(8'h1C, 32'h0, "R5 ignored high");
        // stop: counter runs until stop reaches sync
        wr(8'h04, 32'h0);
        ticks(3);
        rd(8'h04, 32'h0, "R2 stop visible");
        rd(8'h20, 32'h6, "R3 steps during stop crossing");
        ticks(2);
        rd(8'h20, 32'h6, "R3 hold while stopped");
        // R6 alarm match on seconds field
        wr(8'h20, 32'h00027FFE);
        wr(8'h1C, 32'h0);
        wr(8'h24, 32'h5);
        rd(8'h24, 32'h5, "R6 alarm readback");
        wr(8'h04, 32'hB);
        rd(8'h04, 32'hA, "R2 arm and wake immediate");
        ticks(3);
        rd(8'h04, 32'hB, "R2 all set");
        ticks(1);
        rd(8'h18, 32'h0, "R6 no flag before match");
        ticks(1);
        rd(8'h18, 32'h1, "R6 flag on match");
        pins(1'b1, 1'b1, "R8 irq and wake");
        wr(8'h04, 32'h3);
        pins(1'b1, 1'b0, "R8 wake gated");
        wr(8'h18, 32'h0);
        rd(8'h18, 32'h1, "R7 zero write no effect");
        wr(8'h18, 32'h1);
        rd(8'h18, 32'h1, "R11 match beats clear");
        wr(8'h24, 32'd100);
        rd(8'h18, 32'h1, "R6 sticky after match ends");
        wr(8'h18, 32'h1);
        rd(8'h18, 32'h0, "R7 clear");
        pins(1'b0, 1'b0, "R8 pins low after clear");
        wr(8'h24, 32'h5);
        wr(8'h24, 32'h6);
        rd(8'h18, 32'h1, "R6 sticky");
        wr(8'h18, 32'hFFFFFFFF);
        rd(8'h18, 32'h0, "R7 clear all ones");
        wr(8'h24, 32'h5);
        wr(8'h04, 32'h1);
        pins(1'b0, 1'b0, "R8 irq gated by arm");
        rd(8'h18, 32'h1, "R6 flag held when disarmed");
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule